// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block is a three-wire serial master that fetches one 16-bit word from a serial EEPROM holding 64 words. A one-cycle start request together with a 6-bit word address begins a transfer. The block raises chip select and shifts out a 9-bit read command, most significant bit first: a start bit of 1, the read opcode `10`, then the address. It then clocks in 16 data bits, most significant bit first, and closes with a termination pulse. It returns the assembled word with a one-cycle completion strobe.

All serial timing derives from one programmable half-period counter. The parameter `HALF_CLKS` sets how many system clocks each half of the serial clock lasts. At a 100 MHz system clock the default value of 4000 gives a 40 µs half-period. Every serial clock pulse is a high half followed by a low half. Data-in changes only at the end of a high half, so it is always set up a full half-period before the next rising edge. Data-out is sampled at the end of each high half.

Top module: `ee_word_reader`

## Requirements
- R1: While reset is active and until the first start, chip select, serial clock, data-in, busy and done are all 0 and the word output is 0.
- R2: The command seen on data-in at the 9 rising serial-clock edges of a transfer is 1, 1, 0, followed by address bits 5 down to 0. Data-in never changes while the serial clock is high.
- R3: Chip select rises on the clock edge that accepts start. It then stays high for one full half-period with the serial clock low before the first rising edge. It remains high through exactly 25 rising edges: 9 for the command and 16 for the data.
- R4: Every high and every low phase of the serial clock during a transfer lasts exactly `HALF_CLKS` system clocks.
- R5: The 16 data bits are captured most significant bit first, each sampled from data-out at the end of a high phase. The word output then equals the addressed EEPROM word.
- R6: After the last data bit, chip select drops. Exactly one further full serial-clock pulse follows with chip select low, and then the transfer completes.
- R7: Done is high for exactly one cycle, `53*HALF_CLKS` clocks after the edge that accepted start. Busy is high from that edge until done, and it is low in the done cycle.
- R8: A start request while busy is ignored. The running transfer keeps its address, its timing and its result.
- R9: The word output changes only in the cycle done is high, and it holds its value until the next done.
- R10: A start presented in the cycle that done is high is accepted, so transfers can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to read a word; ignored while busy |
| addr_i | input | ADDR_W | Word address, sampled with an accepted start |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data toward the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| busy_o | output | 1 | High while a transfer is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| word_o | output | DATA_W | Last word read, held until the next completion |

## Verification
The hardest condition to create from the ports is a second start request that lands while a transfer is running, and especially one in the very first busy cycle or in the final cycle before done. A wrong design could then restart or re-sample the address without disturbing the serial pins much. The stimulus places such requests at those exact cycle offsets and at random offsets, each carrying a different address. It then checks that the EEPROM model still received the original address, that the latency was unchanged, and that the returned word belongs to the original address. A start placed in the cycle done is high covers the boundary where a request must be accepted.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEL  = 3'd1,
    ST_CMD  = 3'd2,
    ST_DATA = 3'd3,
    ST_TERM = 3'd4
  } rd_state_e;

  // start bit followed by the two-bit read opcode, sent ahead of the address
  localparam logic [2:0] RD_PREFIX = 3'b110;

endpackage

// File: rtl/ee_rst_sync.sv
module ee_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      meta_q  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_n_s <= meta_q;
    end
  end

endmodule

// File: rtl/ee_half_timer.sv
module ee_half_timer #(
  parameter int unsigned HALF_CLKS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (HALF_CLKS > 1) begin : g_spacing
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
    end
  endgenerate

endmodule

// File: rtl/ee_shift_unit.sv
module ee_shift_unit #(
  parameter int unsigned CMD_W  = 9,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              shift_cmd,
  input  logic              capture,
  input  logic              sdo,
  output logic              di_o,
  output logic [DATA_W-1:0] data_o
);

  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [DATA_W-1:0] dat_q, dat_d;

  always_comb begin
    cmd_d = cmd_q;
    dat_d = dat_q;
    if (load)           cmd_d = cmd_in;
    else if (shift_cmd) cmd_d = {cmd_q[CMD_W-2:0], 1'b0};
    if (capture)        dat_d = {dat_q[DATA_W-2:0], sdo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      dat_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      dat_q <= dat_d;
    end
  end

  assign di_o   = cmd_q[CMD_W-1];
  assign data_o = dat_q;

  AST_LOAD_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(shift_cmd || capture)); // R8

endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import ee_rd_pkg::*;
#(
  parameter int unsigned HALF_CLKS = 4000,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic              ee_di_o,
  input  logic              ee_do_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word_o
);

  localparam int unsigned CMD_W    = ADDR_W + 3;
  localparam int unsigned MAX_BITS = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int unsigned BC_W     = $clog2(MAX_BITS);
  localparam logic [BC_W-1:0] CMD_LAST  = BC_W'(CMD_W - 1);
  localparam logic [BC_W-1:0] DATA_LAST = BC_W'(DATA_W - 1);

  logic rst_s;
  ee_rst_sync u_rst (.clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_s));

  rd_state_e         state_q, state_d;
  logic              hi_q, hi_d;
  logic [BC_W-1:0]   bit_q, bit_d;
  logic              cs_q, cs_d, sk_q, sk_d, busy_q, busy_d, done_q, done_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              tick, load, shift_cmd, capture, di_w;
  logic [DATA_W-1:0] data_w;
  logic              run;

  assign run = (state_q != ST_IDLE);

  ee_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_s), .run(run), .tick(tick)
  );

  ee_shift_unit #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_s), .load(load), .cmd_in({RD_PREFIX, addr_i}),
    .shift_cmd(shift_cmd), .capture(capture), .sdo(ee_do_i),
    .di_o(di_w), .data_o(data_w)
  );

  // next-state process
  always_comb begin
    state_d   = state_q;
    hi_d      = hi_q;
    bit_d     = bit_q;
    done_d    = 1'b0;
    word_d    = word_q;
    load      = 1'b0;
    shift_cmd = 1'b0;
    capture   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        hi_d  = 1'b0;
        bit_d = '0;
        if (start_i) begin
          state_d = ST_SEL;
          load    = 1'b1;
        end
      end
      ST_SEL: if (tick) begin
        state_d = ST_CMD;
        hi_d    = 1'b1;
        bit_d   = '0;
      end
      ST_CMD: if (tick) begin
        if (hi_q) begin
          hi_d      = 1'b0;
          shift_cmd = 1'b1;
        end else if (bit_q == CMD_LAST) begin
          state_d = ST_DATA;
          hi_d    = 1'b1;
          bit_d   = '0;
        end else begin
          hi_d  = 1'b1;
          bit_d = bit_q + 1'b1;
        end
      end
      ST_DATA: if (tick) begin
        if (hi_q) begin
          hi_d    = 1'b0;
          capture = 1'b1;
        end else if (bit_q == DATA_LAST) begin
          state_d = ST_TERM;
          hi_d    = 1'b1;
          bit_d   = '0;
        end else begin
          hi_d  = 1'b1;
          bit_d = bit_q + 1'b1;
        end
      end
      ST_TERM: if (tick) begin
        if (hi_q) begin
          hi_d = 1'b0;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          word_d  = data_w;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    cs_d   = (state_d == ST_SEL) || (state_d == ST_CMD) || (state_d == ST_DATA);
    sk_d   = hi_d && (state_d != ST_IDLE) && (state_d != ST_SEL);
    busy_d = (state_d != ST_IDLE);
  end

  // register process
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      hi_q    <= 1'b0;
      bit_q   <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
      bit_q   <= bit_d;
      cs_q    <= cs_d;
      sk_q    <= sk_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      if (done_d) word_q <= word_d;
    end
  end

  assign ee_cs_o = cs_q;
  assign ee_sk_o = sk_q;
  assign ee_di_o = di_w;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign word_o  = word_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |=> !done_q); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |-> !busy_q); // R7
  AST_DI_STILL_HIGH: assert property (@(posedge clk) disable iff (!rst_s)
    (sk_q && $past(sk_q)) |-> $stable(di_w)); // R2
  AST_TERM_CS_LOW: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_TERM) |-> !cs_q); // R6
  AST_SK_IN_TXN: assert property (@(posedge clk) disable iff (!rst_s)
    sk_q |-> busy_q); // R3
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    !done_q |-> $stable(word_q)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_q && start_i) |=> (busy_q || done_q)); // R8

endmodule

// File: tb/ee_word_reader_test.sv
module ee_word_reader_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int LAT        = 53 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  addr = '0;
  logic        ee_do = 1'b0;
  logic        cs, sk, di, busy, done;
  logic [15:0] word;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [15:0] mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_word_reader #(.HALF_CLKS(HALF), .ADDR_W(6), .DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(ee_do),
    .busy_o(busy), .done_o(done), .word_o(word)
  );

  function automatic logic [15:0] fill_word(int a);
    return 16'((a * 2731) ^ 16'hA55A ^ (a << 9));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // EEPROM model
  int         edges = 0;
  int         term_cnt = 0;
  bit         in_txn = 1'b0;
  logic [8:0] rx_cmd = '0;

  always @(posedge sk) begin
    if (cs) begin
      if (!in_txn) begin
        edges  = 0;
        rx_cmd = '0;
        in_txn = 1'b1;
      end
      edges++;
      if (edges <= 9) rx_cmd = {rx_cmd[7:0], di};
      else if (edges <= 25) ee_do <= mem[rx_cmd[5:0]][25 - edges];
    end else begin
      term_cnt++;
      in_txn = 1'b0;
      ee_do <= 1'b0;
    end
  end

  // serial clock phase length monitor (R4)
  int   run_len = 0;
  logic sk_prev = 1'b0;
  bit   had_high = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sk !== sk_prev) begin
        if (sk_prev) chk(run_len == HALF, "R4 high phase length", run_len, HALF);
        else if (had_high) chk(run_len == HALF, "R4 low phase length", run_len, HALF);
        if (sk) had_high = 1'b1;
        run_len = 1;
      end else begin
        run_len++;
      end
      if (!busy) had_high = 1'b0;
      sk_prev = sk;
    end
  end

  task automatic do_read(logic [5:0] a, int inject_at, logic [5:0] other);
    int n;
    int t0;
    logic [15:0] w_done;
    t0 = term_cnt;
    start = 1'b1;
    addr  = a;
    @(negedge clk);
    start = 1'b0;
    addr  = other;
    n = 1;
    chk(busy && cs && !sk, "R3 select phase before first clock", {busy, cs, sk}, 3'b110);
    while (!done && n < LAT + 100) begin
      if (n == inject_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk(done == 1'b1, "R7 completion seen", done, 1);
    chk(n == LAT + 1, "R7 latency", n, LAT + 1);
    chk(!busy, "R7 busy low with done", busy, 0);
    chk(word == mem[a], "R5 returned word", word, mem[a]);
    chk(rx_cmd == {3'b110, a}, "R2 command bits", rx_cmd, {3'b110, a});
    chk(edges == 25, "R3 rising edges under select", edges, 25);
    chk(term_cnt - t0 == 1, "R6 termination pulse", term_cnt - t0, 1);
    if (inject_at > 0) chk(word == mem[a], "R8 start while busy ignored", word, mem[a]);
    w_done = word;
    @(negedge clk);
    chk(!done, "R7 done single cycle", done, 0);
    chk(word == w_done, "R9 word held", word, w_done);
    chk(!cs && !sk && !di, "R1 idle pins", {cs, sk, di}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    for (int i = 0; i < 64; i++) mem[i] = fill_word(i);
    mem[0]  = 16'hFFFF;
    mem[63] = 16'h8001;
    mem[21] = 16'h0000;

    repeat (3) @(negedge clk);
    chk({cs, sk, di, busy, done} == 5'b0, "R1 pins in reset", {cs, sk, di, busy, done}, 0);
    chk(word == 16'h0, "R1 word in reset", word, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({cs, sk, di, busy, done} == 5'b0, "R1 pins after reset", {cs, sk, di, busy, done}, 0);

    // directed corners
    do_read(6'd0, 0, 6'd63);
    do_read(6'd63, 0, 6'd0);
    do_read(6'd21, 1, 6'd42);
    do_read(6'd42, LAT - 1, 6'd21);

    // back-to-back: start in the cycle done is high (R10)
    start = 1'b1; addr = 6'd5;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1; addr = 6'd9;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 start in done cycle accepted", busy, 1);
    while (!done) @(negedge clk);
    chk(word == mem[9], "R10 back-to-back word", word, mem[9]);
    chk(rx_cmd == {3'b110, 6'd9}, "R10 back-to-back command", rx_cmd, {3'b110, 6'd9});
    @(negedge clk);

    // constrained random reads
    for (int k = 0; k < 20; k++) begin
      logic [5:0] ra, ro;
      int inj;
      ra  = 6'($urandom);
      ro  = ~ra;
      inj = (($urandom % 2) == 0) ? 0 : 1 + int'($urandom % (LAT - 1));
      do_read(ra, inj, ro);
      repeat ($urandom % 4) @(negedge clk);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule